// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block sits at the head of a multithreaded pipeline front end. It holds one program counter per hardware thread and decides, every clock cycle, which thread may issue. Its output is the chosen thread number, that thread's program counter and a flag that says whether an issue happens in this cycle. Each thread reports two conditions. A short stall flag blocks the thread for the current cycle. A miss flag reports a costly long-latency event, such as a miss in the second-level cache.

Two scheduling policies are available through a mode pin. In interleaved mode the block rotates over the threads every cycle and passes over any thread that is blocked. In block mode it stays on one thread and does not issue while that thread has a short stall. It moves to another thread only when the current thread reports a miss. It then holds issue off for a fixed number of refill cycles, which models the cost of restarting the pipeline. Every thread keeps its own program counter, so a switch needs no save or restore. The issue output has no ready input. Back-pressure reaches the block only through the per-thread stall and miss flags, and these act in the same cycle as they are driven. The issue outputs are combinational from registered state and the current flags.

Top module: `mt_thread_sel`

## Requirements
- R1: While rst_n is low at a clock edge, every program counter loads reset_vec, the rotation start point goes to thread 0 and the block-mode current thread goes to thread 0. The first cycle after reset with thread 0 unblocked issues thread 0 at reset_vec. Each other thread, when it first issues, shows reset_vec.
- R2: A thread is eligible only when both its stall bit and its miss bit are 0. issue_valid is never 1 for an ineligible thread. In interleaved mode (mode_coarse = 0), issue_valid is 1 exactly when at least one thread is eligible.
- R3: In interleaved mode the issued thread is the first eligible thread found when searching upward from one past the previously issued thread, wrapping from NUM_THREADS-1 to 0. The issued thread can therefore change every cycle.
- R4: When every thread is ineligible, issue_valid is 0 and the rotation start point is held. The next issue starts its search from the same place as it would have before the blocked cycles.
- R5: Each issue adds PC_STEP (default 4) to the issuing thread's program counter at the clock edge. The counters of the other threads keep their values.
- R6: With pc_wr_en = 1, the program counter of thread pc_wr_tid takes pc_wr_data at the clock edge. If that thread also issues in the same cycle, the written value wins over the increment.
- R7: In block mode (mode_coarse = 1), only the current thread issues. A short stall (stall bit 1, miss bit 0) on the current thread gives issue_valid = 0 and no switch. Issue resumes on the same thread when the stall clears.
- R8: In block mode with no refill in progress, a miss on the current thread selects the next eligible thread after it in rotation order. issue_valid is 0 in the miss cycle and in the REFILL_CYC (default 3) cycles that follow. Stall and miss inputs have no effect during the refill cycles. If no other thread is eligible, the current thread is kept and nothing issues.
- R9: When the block issues in interleaved mode, the issued thread becomes the block-mode current thread. When the block issues in block mode, the rotation start point moves to one past the current thread. A change of mode therefore continues from the last issued thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reset_vec | input | PC_W | Value loaded into every program counter during reset |
| mode_coarse | input | 1 | 0 selects interleaved mode, 1 selects block mode |
| stall | input | NUM_THREADS | Per-thread short stall flags |
| miss | input | NUM_THREADS | Per-thread long-latency miss flags |
| pc_wr_en | input | 1 | Program counter write enable |
| pc_wr_tid | input | TID_W | Thread whose program counter is written |
| pc_wr_data | input | PC_W | New program counter value |
| issue_valid | output | 1 | An issue takes place this cycle |
| issue_tid | output | TID_W | Selected thread |
| issue_pc | output | PC_W | Program counter of the selected thread |

## Verification
A wrong rotation start point or a wrong current-thread register shows up on issue_tid in the first cycle in which more than one thread is eligible. A refill counter that is too short or too long moves the first issue after a miss by one or more cycles. A lost or duplicated program counter increment appears on issue_pc the next time that thread is chosen, which is usually within a few cycles in interleaved mode. The stimulus mixes random stall, miss and write patterns with directed cases: all threads blocked, a write in the same cycle as an issue, a short stall in block mode, and a miss with no other eligible thread. Every cycle is compared against a model built from the requirements.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;

  typedef enum logic {
    SEL_FINE   = 1'b0,
    SEL_COARSE = 1'b1
  } sel_mode_e;

endpackage

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = (NUM_THREADS < 2) ? 1 : $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] req,
  input  logic [TID_W-1:0]       start,
  output logic                   found,
  output logic [TID_W-1:0]       idx
);

  logic [TID_W-1:0] cand;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    cand  = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      cand = TID_W'((int'(start) + k) % NUM_THREADS);
      if (!found && req[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end

endmodule

// File: rtl/mt_pc_bank.sv
module mt_pc_bank #(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 32,
  parameter int PC_STEP     = 4,
  localparam int TID_W = (NUM_THREADS < 2) ? 1 : $clog2(NUM_THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  reset_vec,
  input  logic             adv_en,
  input  logic [TID_W-1:0] adv_tid,
  input  logic             wr_en,
  input  logic [TID_W-1:0] wr_tid,
  input  logic [PC_W-1:0]  wr_data,
  input  logic [TID_W-1:0] rd_tid,
  output logic [PC_W-1:0]  rd_pc
);

  logic [PC_W-1:0] pc_q [NUM_THREADS];

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thread
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_q[g] <= reset_vec;
      end else if (wr_en && (wr_tid == TID_W'(g))) begin
        pc_q[g] <= wr_data;
      end else if (adv_en && (adv_tid == TID_W'(g))) begin
        pc_q[g] <= pc_q[g] + PC_W'(PC_STEP);
      end
    end
  end

  assign rd_pc = pc_q[rd_tid];

endmodule

// File: rtl/mt_thread_sel.sv
module mt_thread_sel
  import mt_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 32,
  parameter int PC_STEP     = 4,
  parameter int REFILL_CYC  = 3,
  localparam int TID_W = (NUM_THREADS < 2) ? 1 : $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PC_W-1:0]        reset_vec,
  input  logic                   mode_coarse,
  input  logic [NUM_THREADS-1:0] stall,
  input  logic [NUM_THREADS-1:0] miss,
  input  logic                   pc_wr_en,
  input  logic [TID_W-1:0]       pc_wr_tid,
  input  logic [PC_W-1:0]        pc_wr_data,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid,
  output logic [PC_W-1:0]        issue_pc
);

  localparam int RF_W = (REFILL_CYC < 1) ? 1 : $clog2(REFILL_CYC + 1);
  localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

  function automatic logic [TID_W-1:0] wrap_inc(input logic [TID_W-1:0] t);
    return (t == LAST_TID) ? '0 : t + 1'b1;
  endfunction

  sel_mode_e              mode;
  logic [NUM_THREADS-1:0] elig;
  logic [NUM_THREADS-1:0] cur_mask;
  logic [TID_W-1:0]       ptr_q;
  logic [TID_W-1:0]       cur_q;
  logic [RF_W-1:0]        refill_q;

  logic                   f_found;
  logic [TID_W-1:0]       f_idx;
  logic                   c_found;
  logic [TID_W-1:0]       c_idx;

  logic                   issue_v;
  logic [TID_W-1:0]       sel;
  logic                   do_switch;

  assign mode     = sel_mode_e'(mode_coarse);
  assign elig     = ~(stall | miss);
  assign cur_mask = {{(NUM_THREADS-1){1'b0}}, 1'b1} << cur_q;

  // interleaved search from the rotation start point
  mt_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_fine_pick (
    .req   (elig),
    .start (ptr_q),
    .found (f_found),
    .idx   (f_idx)
  );

  // block-mode successor search, excluding the current thread
  mt_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_coarse_pick (
    .req   (elig & ~cur_mask),
    .start (wrap_inc(cur_q)),
    .found (c_found),
    .idx   (c_idx)
  );

  always_comb begin
    issue_v   = 1'b0;
    sel       = cur_q;
    do_switch = 1'b0;
    if (mode == SEL_FINE) begin
      issue_v = f_found;
      sel     = f_idx;
    end else if (refill_q != '0) begin
      issue_v = 1'b0;
    end else if (miss[cur_q]) begin
      do_switch = c_found;
    end else if (!stall[cur_q]) begin
      issue_v = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      cur_q    <= '0;
      refill_q <= '0;
    end else if (mode == SEL_FINE) begin
      refill_q <= '0;
      if (issue_v) begin
        ptr_q <= wrap_inc(sel);
        cur_q <= sel;
      end
    end else begin
      if (refill_q != '0) begin
        refill_q <= refill_q - 1'b1;
      end else if (do_switch) begin
        cur_q    <= c_idx;
        refill_q <= RF_W'(REFILL_CYC);
      end
      if (issue_v) begin
        ptr_q <= wrap_inc(cur_q);
      end
    end
  end

  mt_pc_bank #(
    .NUM_THREADS (NUM_THREADS),
    .PC_W        (PC_W),
    .PC_STEP     (PC_STEP)
  ) u_pc_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_vec (reset_vec),
    .adv_en    (issue_v),
    .adv_tid   (sel),
    .wr_en     (pc_wr_en),
    .wr_tid    (pc_wr_tid),
    .wr_data   (pc_wr_data),
    .rd_tid    (sel),
    .rd_pc     (issue_pc)
  );

  assign issue_valid = issue_v;
  assign issue_tid   = sel;

endmodule

// File: rtl/mt_thread_sel_chk.sv
module mt_thread_sel_chk #(
  parameter int NUM_THREADS = 4,
  parameter int REFILL_CYC  = 3,
  localparam int TID_W = (NUM_THREADS < 2) ? 1 : $clog2(NUM_THREADS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_coarse,
  input logic [NUM_THREADS-1:0] stall,
  input logic [NUM_THREADS-1:0] miss,
  input logic                   issue_valid,
  input logic [TID_W-1:0]       issue_tid
);

  localparam int GAP_W = $clog2(REFILL_CYC + 2) + 1;

  logic [GAP_W-1:0] gap_q;
  logic [TID_W-1:0] last_tid_q;
  logic             seen_q;

  // idle cycles since the last issue, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q      <= '0;
      last_tid_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      if (issue_valid) begin
        gap_q      <= '0;
        last_tid_q <= issue_tid;
      end else if (gap_q <= GAP_W'(REFILL_CYC)) begin
        gap_q <= gap_q + 1'b1;
      end
      if (!mode_coarse) begin
        seen_q <= 1'b0;
      end else if (issue_valid) begin
        seen_q <= 1'b1;
      end
    end
  end

  assert_issue_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (!stall[issue_tid] && !miss[issue_tid]));

  assert_fine_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_coarse && ((stall | miss) != {NUM_THREADS{1'b1}})) |-> issue_valid);

  assert_all_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall | miss) == {NUM_THREADS{1'b1}}) |-> !issue_valid);

  assert_coarse_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_coarse && issue_valid && $past(mode_coarse && issue_valid))
      |-> (issue_tid == $past(issue_tid)));

  assert_refill_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_coarse && issue_valid && seen_q && (issue_tid != last_tid_q))
      |-> (gap_q >= GAP_W'(REFILL_CYC)));

endmodule

bind mt_thread_sel mt_thread_sel_chk #(
  .NUM_THREADS (NUM_THREADS),
  .REFILL_CYC  (REFILL_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_coarse (mode_coarse),
  .stall       (stall),
  .miss        (miss),
  .issue_valid (issue_valid),
  .issue_tid   (issue_tid)
);

// File: tb/mt_thread_sel_bench.sv
`timescale 1ns/1ps
module mt_thread_sel_bench;

  localparam int T      = 4;
  localparam int STEP   = 4;
  localparam int REFILL = 3;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_coarse;
  logic [3:0] stall, miss;
  logic       pc_wr_en;
  logic [1:0] pc_wr_tid;
  logic [31:0] pc_wr_data;
  logic       issue_valid;
  logic [1:0] issue_tid;
  logic [31:0] issue_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mt_thread_sel u_mt_thread_sel (
    .clk(clk), .rst_n(rst_n), .reset_vec(RV), .mode_coarse(mode_coarse),
    .stall(stall), .miss(miss), .pc_wr_en(pc_wr_en), .pc_wr_tid(pc_wr_tid),
    .pc_wr_data(pc_wr_data), .issue_valid(issue_valid), .issue_tid(issue_tid),
    .issue_pc(issue_pc)
  );

  // reference model state
  logic [31:0] m_pc [T];
  int m_ptr, m_cur, m_ref;
  bit e_v, e_sw;
  int e_tid, e_next;

  function automatic int find_next(logic [3:0] req, int start);
    for (int k = 0; k < T; k++) begin
      if (req[(start + k) % T]) return (start + k) % T;
    end
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < T; i++) m_pc[i] = RV;
    m_ptr = 0; m_cur = 0; m_ref = 0;
  endtask

  task automatic model_eval();
    logic [3:0] el;
    el = ~(stall | miss);
    e_v = 1'b0; e_sw = 1'b0; e_tid = m_cur; e_next = -1;
    if (!mode_coarse) begin
      e_tid = find_next(el, m_ptr);
      e_v = (e_tid >= 0);
    end else if (m_ref > 0) begin
      e_v = 1'b0;
    end else if (miss[m_cur]) begin
      el[m_cur] = 1'b0;
      e_next = find_next(el, (m_cur + 1) % T);
      e_sw = (e_next >= 0);
    end else if (!stall[m_cur]) begin
      e_v = 1'b1;
    end
  endtask

  task automatic model_commit();
    if (!mode_coarse) begin
      m_ref = 0;
      if (e_v) begin m_ptr = (e_tid + 1) % T; m_cur = e_tid; end
    end else begin
      if (m_ref > 0) m_ref--;
      else if (e_sw) begin m_cur = e_next; m_ref = REFILL; end
      if (e_v) m_ptr = (m_cur + 1) % T;
    end
    if (e_v) m_pc[e_tid] = m_pc[e_tid] + STEP;
    if (pc_wr_en) m_pc[pc_wr_tid] = pc_wr_data;
  endtask

  // one cycle: drive, settle, compare, clock, update model
  task automatic cyc(bit md, logic [3:0] st, logic [3:0] ms, bit we,
                     logic [1:0] wt, logic [31:0] wd, string tag);
    mode_coarse = md; stall = st; miss = ms;
    pc_wr_en = we; pc_wr_tid = wt; pc_wr_data = wd;
    #1;
    model_eval();
    check(issue_valid == e_v, tag, "issue_valid", longint'(issue_valid), longint'(e_v));
    if (e_v) begin
      check(int'(issue_tid) == e_tid, tag, "issue_tid", longint'(issue_tid), longint'(e_tid));
      check(issue_pc == m_pc[e_tid], tag, "issue_pc", longint'(issue_pc), longint'(m_pc[e_tid]));
    end
    @(posedge clk);
    model_commit();
    #1;
  endtask

  task automatic idle(bit md, logic [3:0] st, logic [3:0] ms, string tag);
    cyc(md, st, ms, 1'b0, 2'd0, 32'd0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; mode_coarse = 1'b0; stall = '0; miss = '0;
    pc_wr_en = 1'b0; pc_wr_tid = '0; pc_wr_data = '0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    model_reset();

    // R1: thread 0 first at reset_vec, then each other thread alone at reset_vec
    idle(1'b0, 4'b0000, 4'b0000, "R1");
    idle(1'b0, 4'b1101, 4'b0000, "R1");
    idle(1'b0, 4'b1011, 4'b0000, "R1");
    idle(1'b0, 4'b0000, 4'b0111, "R1");

    // R3: free rotation, then with skipped threads
    repeat (6) idle(1'b0, 4'b0000, 4'b0000, "R3");
    repeat (4) idle(1'b0, 4'b0101, 4'b0000, "R3");

    // R4: everything blocked, then released
    repeat (3) idle(1'b0, 4'b1010, 4'b0101, "R4");
    idle(1'b0, 4'b0000, 4'b0000, "R4");
    idle(1'b0, 4'b0000, 4'b0000, "R4");

    // R6: write to thread 2, then read it; write wins over same-cycle issue
    cyc(1'b0, 4'b1111, 4'b0000, 1'b1, 2'd2, 32'h0000_8000, "R6");
    idle(1'b0, 4'b1011, 4'b0000, "R6");
    cyc(1'b0, 4'b1011, 4'b0000, 1'b1, 2'd2, 32'h0000_9000, "R6");
    idle(1'b0, 4'b1011, 4'b0000, "R6");
    idle(1'b0, 4'b1011, 4'b0000, "R5");

    // R9, R7: block mode stays on last issued thread, short stall holds it
    repeat (3) idle(1'b1, 4'b0000, 4'b0000, "R9");
    repeat (2) idle(1'b1, 4'b0100, 4'b0000, "R7");
    repeat (2) idle(1'b1, 4'b0000, 4'b0000, "R7");

    // R8: miss with others eligible -> refill then switch
    idle(1'b1, 4'b0000, 4'b0100, "R8");
    repeat (REFILL) idle(1'b1, 4'b0000, 4'b1111, "R8");
    repeat (2) idle(1'b1, 4'b0000, 4'b0000, "R8");
    // R8: miss with no other eligible thread -> stays, no issue
    repeat (2) idle(1'b1, 4'b1111, 4'b1000, "R8");
    idle(1'b1, 4'b0000, 4'b0000, "R8");

    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      bit md;
      md = ph[0];
      for (int n = 0; n < 400; n++) begin
        logic [3:0] st, ms;
        bit we;
        st = '0; ms = '0;
        for (int b = 0; b < T; b++) begin
          st[b] = ($urandom_range(0, 99) < 30);
          ms[b] = ($urandom_range(0, 99) < (md ? 6 : 10));
        end
        we = ($urandom_range(0, 99) < 8);
        cyc(md, st, ms, we, 2'($urandom_range(0, 3)), $urandom,
            md ? "R8" : "R3");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule